// File: doc/BRIEF.md
# Strobe-Controlled FIFO with Replay and Half-Full Flag

This block is a first-in first-out buffer of 9-bit words, 512 deep by default, built on a dual-port memory. Active-low write and read strobes are sampled on a single clock. A write stores the input word at the write pointer. A read moves the word at the read pointer into a registered output. The block ignores a write while it is full and a read while it is empty, so it can neither overrun nor underrun.

Status outputs report empty, full and at-least-half occupancy. An active-low replay input rewinds the read side to memory address zero, so that stored data can be read a second time. The write pointer is not moved by a replay. A mode input gives the half-full pin a second use: in cascade mode the pin carries a one-cycle token that fires when a write fills the last memory location, which hands write control to the next buffer in a depth chain.

Top module: `fifo_rt`

## Requirements
- R1: Words leave `rdata_o` in the order in which they were accepted, each 9 bits wide.
- R2: A clock edge with `wr_ni` low and the buffer not full stores `wdata_i`. A clock edge with `rd_ni` low and the buffer not empty puts the oldest word on `rdata_o`, where it is visible after that edge.
- R3: A write request while full is dropped. The count stays at DEPTH and the stored words are unchanged.
- R4: A read request while empty is dropped. `rdata_o` holds its previous value and `empty_o` stays high.
- R5: `rd_oe_o` is high exactly while `rd_ni` is low.
- R6: With `mode_i`=0, `hf_xo_o` is high while the count is at least DEPTH/2.
- R7: `empty_o` is high exactly when the count is 0, and `full_o` is high exactly when the count equals DEPTH.
- R8: `rt_ni` low at a clock edge with both strobes high sets the read pointer to address 0 and leaves the write pointer unchanged. The count becomes the number of words written since reset, capped at DEPTH.
- R9: `rt_ni` low while either strobe is low has no replay effect. Any read or write in that cycle proceeds normally.
- R10: With `mode_i`=1, `hf_xo_o` is high for exactly one cycle after a write into address DEPTH-1, and low otherwise.
- R11: A simultaneous read and write while neither empty nor full leaves the count unchanged. The flags follow the count in the same cycle.
- R12: Reset (`rst_ni` low) clears both pointers and the count, sets `empty_o` high, and drives `full_o`, `hf_xo_o` and `rdata_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that samples the strobes |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_ni | input | 1 | Active-low write strobe |
| rd_ni | input | 1 | Active-low read strobe |
| rt_ni | input | 1 | Active-low replay request |
| mode_i | input | 1 | 0 = standalone (half-full), 1 = cascade (expansion token) |
| wdata_i | input | 9 | Write data |
| rdata_o | output | 9 | Registered read data |
| rd_oe_o | output | 1 | Output-enable, high while a read is requested |
| empty_o | output | 1 | Buffer holds no words |
| full_o | output | 1 | Buffer holds DEPTH words |
| hf_xo_o | output | 1 | Half-full flag or expansion-out token, chosen by mode_i |

## Verification
The hardest cases to reach are a replay after the write pointer has wrapped, where the count must come back capped at DEPTH, and the expansion token, which needs exactly DEPTH writes after reset. The stimulus fills the buffer to full, pushes one more write against it, drains it, and then replays, so the wrapped path is exercised on the real default depth. A separate phase after reset writes DEPTH-1 words in cascade mode and then one more, and watches the token on both sides of that last write. A replay request made together with a read confirms that it has no replay effect.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef enum logic {
    MODE_SOLO  = 1'b0,
    MODE_CHAIN = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int DW    = 9,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  input  logic          rt_req_i,
  output logic          wr_ok_o,
  output logic          rd_ok_o,
  output logic          last_wr_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [AW-1:0] ADDR_TOP = AW'(DEPTH - 1);

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          wrapped_q;
  logic          rt_ok;

  // replay only with both strobes idle
  assign rt_ok     = rt_req_i && !wr_req_i && !rd_req_i;
  assign wr_ok_o   = wr_req_i && (cnt_q != CNT_FULL);
  assign rd_ok_o   = rd_req_i && (cnt_q != '0);
  assign last_wr_o = wr_ok_o && (wptr_q == ADDR_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      cnt_q     <= '0;
      wrapped_q <= 1'b0;
    end else if (rt_ok) begin
      rptr_q <= '0;
      cnt_q  <= wrapped_q ? CNT_FULL : {1'b0, wptr_q};
    end else begin
      if (wr_ok_o)   wptr_q    <= wptr_q + 1'b1;
      if (last_wr_o) wrapped_q <= 1'b1;
      if (rd_ok_o)   rptr_q    <= rptr_q + 1'b1;
      unique case ({wr_ok_o, rd_ok_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign waddr_o = wptr_q;
  assign raddr_o = rptr_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/fifo_rt_flags.sv
module fifo_rt_flags
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  fifo_mode_e    mode_i,
  input  logic          last_wr_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          hf_xo_o
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);

  logic xo_q;
  logic half;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) xo_q <= 1'b0;
    else         xo_q <= last_wr_i;
  end

  assign empty_o = (count_i == '0);
  assign full_o  = (count_i == CNT_FULL);
  assign half    = (count_i >= CNT_HALF);

  always_comb begin
    unique case (mode_i)
      MODE_CHAIN: hf_xo_o = xo_q;
      default:    hf_xo_o = half;
    endcase
  end
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 512
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ni,
  input  logic          rd_ni,
  input  logic          rt_ni,
  input  logic          mode_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rd_oe_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          hf_xo_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          wr_ok, rd_ok, last_wr;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] count;

  fifo_rt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_req_i  (!wr_ni),
    .rd_req_i  (!rd_ni),
    .rt_req_i  (!rt_ni),
    .wr_ok_o   (wr_ok),
    .rd_ok_o   (rd_ok),
    .last_wr_o (last_wr),
    .waddr_o   (waddr),
    .raddr_o   (raddr),
    .count_o   (count)
  );

  fifo_rt_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ok),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .re_i    (rd_ok),
    .raddr_i (raddr),
    .rdata_o (rdata_o)
  );

  fifo_rt_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .count_i   (count),
    .mode_i    (fifo_mode_e'(mode_i)),
    .last_wr_i (last_wr),
    .empty_o   (empty_o),
    .full_o    (full_o),
    .hf_xo_o   (hf_xo_o)
  );

  assign rd_oe_o = !rd_ni;
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int DW    = 9,
  parameter int DEPTH = 512
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_ni,
  input logic          rd_ni,
  input logic          rt_ni,
  input logic          mode_i,
  input logic [DW-1:0] rdata_o,
  input logic          empty_o,
  input logic          full_o,
  input logic          hf_xo_o
);
  initial begin
    assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
      else $error("DEPTH must be a power of two");
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !wr_ni && rd_ni && rt_ni |=> full_o);

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && !rd_ni && wr_ni |=> empty_o && $stable(rdata_o));

  assert_flags_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));

  assert_half_on_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i && full_o |-> hf_xo_o);

  assert_replay_no_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rt_ni && rd_ni && wr_ni |=> $stable(rdata_o));

  assert_token_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i && hf_xo_o |=> !hf_xo_o || !mode_i);

  assert_rw_steady_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_o && !full_o && !wr_ni && !rd_ni |=> $stable(empty_o) && $stable(full_o));
endmodule

bind fifo_rt fifo_rt_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_ni   (wr_ni),
  .rd_ni   (rd_ni),
  .rt_ni   (rt_ni),
  .mode_i  (mode_i),
  .rdata_o (rdata_o),
  .empty_o (empty_o),
  .full_o  (full_o),
  .hf_xo_o (hf_xo_o)
);

// File: tb/fifo_rt_test.sv
`timescale 1ns/1ps
module fifo_rt_test;
  localparam int DW    = 9;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_ni = 1'b1, rd_ni = 1'b1, rt_ni = 1'b1, mode = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata_o;
  logic rd_oe_o, empty_o, full_o, hf_xo_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fifo_rt #(.DW(DW), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_ni(wr_ni), .rd_ni(rd_ni), .rt_ni(rt_ni),
    .mode_i(mode), .wdata_i(wdata), .rdata_o(rdata_o), .rd_oe_o(rd_oe_o),
    .empty_o(empty_o), .full_o(full_o), .hf_xo_o(hf_xo_o)
  );

  // behavioural reference
  int m_mem [DEPTH];
  int m_wp, m_rp, m_cnt;
  bit m_wrap, m_xo;
  int m_rd;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_wp = 0; m_rp = 0; m_cnt = 0; m_wrap = 0; m_xo = 0; m_rd = 0;
    end else begin
      bit wf, rf;
      wf = !wr_ni && m_cnt < DEPTH;
      rf = !rd_ni && m_cnt > 0;
      m_xo = 0;
      if (!rt_ni && wr_ni && rd_ni) begin
        m_rp = 0;
        m_cnt = m_wrap ? DEPTH : m_wp;
      end else begin
        if (wf) begin
          m_mem[m_wp] = int'(wdata);
          if (m_wp == DEPTH - 1) begin m_xo = 1; m_wrap = 1; end
          m_wp = (m_wp + 1) % DEPTH;
          m_cnt++;
        end
        if (rf) begin
          m_rd = m_mem[m_rp];
          m_rp = (m_rp + 1) % DEPTH;
          m_cnt--;
        end
      end
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(int'(rdata_o), m_rd, "R1 rdata order");
      chk(int'(rd_oe_o), int'(!rd_ni), "R5 output enable");
      chk(int'(empty_o), int'(m_cnt == 0), "R7 empty");
      chk(int'(full_o), int'(m_cnt == DEPTH), "R7 full");
      if (mode) chk(int'(hf_xo_o), int'(m_xo), "R10 token");
      else      chk(int'(hf_xo_o), int'(m_cnt >= DEPTH / 2), "R6 half");
    end
  end

  task automatic cyc(input logic w, input logic r, input logic t, input logic [DW-1:0] d);
    @(posedge clk); #2;
    wr_ni = w; rd_ni = r; rt_ni = t; wdata = d;
  endtask

  task automatic idle();
    cyc(1, 1, 1, '0);
  endtask

  task automatic do_reset(input logic md);
    @(posedge clk); #2;
    rst_ni = 0; wr_ni = 1; rd_ni = 1; rt_ni = 1; mode = md;
    repeat (2) @(posedge clk);
    #2 rst_ni = 1;
  endtask

  task automatic write_n(input int n, input int base);
    for (int i = 0; i < n; i++) cyc(0, 1, 1, DW'(base + i));
    idle();
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 1, '0);
    idle();
  endtask

  task automatic drain(output int n);
    n = 0;
    cyc(1, 0, 1, '0);
    forever begin
      @(negedge clk);
      if (empty_o) break;
      n++;
    end
    idle();
  endtask

  initial begin
    #(20 * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    do_reset(0);
    @(negedge clk);
    chk(int'(empty_o), 1, "R12 empty after reset");
    chk(int'(full_o), 0, "R12 full after reset");
    chk(int'(hf_xo_o), 0, "R12 half after reset");
    chk(int'(rdata_o), 0, "R12 rdata after reset");

    // basic order
    write_n(5, 'h101);
    drain(n);
    chk(n, 5, "R2 words read back");
    @(negedge clk);
    chk(int'(rdata_o), 'h105, "R1 last word");

    // read while empty
    read_n(3);
    @(negedge clk);
    chk(int'(rdata_o), 'h105, "R4 rdata held on empty read");
    chk(int'(empty_o), 1, "R4 still empty");

    // simultaneous read and write mid-range
    write_n(3, 'h020);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, DW'('h030 + i));
    idle();
    drain(n);
    chk(n, 3, "R11 count kept across rd+wr");

    // fill, overflow, drain
    do_reset(0);
    write_n(DEPTH / 2 - 1, 'h000);
    @(negedge clk);
    chk(int'(hf_xo_o), 0, "R6 below half");
    write_n(1, 'h0ff);
    @(negedge clk);
    chk(int'(hf_xo_o), 1, "R6 at half");
    write_n(DEPTH / 2, 'h100);
    @(negedge clk);
    chk(int'(full_o), 1, "R7 full at depth");
    write_n(1, 'h1aa);
    @(negedge clk);
    chk(int'(full_o), 1, "R3 still full after extra write");
    drain(n);
    chk(n, DEPTH, "R3 extra write dropped");

    // replay after wrap restores full count
    cyc(1, 1, 0, '0);
    idle();
    @(negedge clk);
    chk(int'(full_o), 1, "R8 replay after wrap gives full");

    // replay without wrap
    do_reset(0);
    write_n(10, 'h040);
    read_n(4);
    cyc(1, 1, 0, '0);
    idle();
    @(negedge clk);
    chk(int'(rdata_o), 'h043, "R8 replay does not read");
    read_n(1);
    @(negedge clk);
    chk(int'(rdata_o), 'h040, "R8 first word after replay");
    read_n(1);
    cyc(1, 0, 0, '0);
    idle();
    @(negedge clk);
    chk(int'(rdata_o), 'h042, "R9 replay with read low ignored");
    drain(n);
    chk(n, 7, "R9 remaining words");

    // cascade token
    do_reset(1);
    write_n(DEPTH - 1, 'h000);
    @(negedge clk);
    chk(int'(hf_xo_o), 0, "R10 no token before last slot");
    write_n(1, 'h1ff);
    @(negedge clk);
    chk(int'(hf_xo_o), 1, "R10 token after last slot");
    @(negedge clk);
    chk(int'(hf_xo_o), 0, "R10 token one cycle");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule